// File: doc/BRIEF.md
# Reset-Surviving Diagnostic Snapshot Unit

This block keeps a multi-word diagnostic snapshot across a system reset so that software can inspect it afterwards. Before the reset, software arms the unit by setting a capture enable in a small control register. When the system reset event arrives with the enable set, the unit latches the parallel dump vector presented at its input. In the same cycle it drops the enable, so the next reset does not overwrite the saved data unless software arms the unit again.

After the reset, software chooses a word with a 4-bit index field in the same control register. It reads that 32-bit word through a data port, and it reads the number of words held through a count port. A sticky lock bit guards the control register. The lock starts at 1, and a write of 0 clears it until the next power-on reset. Only the unit's own power-on reset clears the snapshot, the count and the lock. A system reset only forces the enable low. The word count is a parameter (1 to 15), so one design serves dumps of different sizes.

Top module: `diag_snapshot_unit`

## Requirements
- R1: After power-on reset the lock reads 1, the control register reads 0x00, the count reads 0 and the data port reads 0.
- R2: A control write while the lock is 1 loads the enable from wdata bit 0 and the index from wdata bits 7:4. The control readback is {index, 3'b000, enable}, so bits 3:1 always read 0.
- R3: A lock write with wdata 0 clears the lock. A lock write with wdata 1 has no effect. Once clear, the lock stays 0 until power-on reset.
- R4: A control write while the lock is 0 leaves both the enable and the index unchanged.
- R5: A system reset event forces the enable to 0 from the next cycle on, and it wins over a control write in the same cycle. The index written in that cycle still takes effect.
- R6: If the enable is 1 in the cycle of a system reset event, that cycle's dump vector is stored and the count becomes NUM_WORDS.
- R7: If the enable is 0 in the cycle of a system reset event, the stored snapshot and the count stay unchanged.
- R8: While the index is below the count, the data port returns stored word k = index, which was taken from dump_in bits 32k+31:32k.
- R9: While the index is greater than or equal to the count, the data port reads 0. This includes the case where no capture has happened yet.
- R10: A system reset event leaves the lock and the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of this unit |
| sys_rst_evt | input | 1 | One-cycle system reset event |
| lock_we | input | 1 | Write strobe for the lock bit |
| lock_wdata | input | 1 | Lock write data (0 clears the lock) |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data: enable at bit 0, index at bits 7:4 |
| dump_in | input | NUM_WORDS*32 | Parallel dump vector, word k at bits 32k+31:32k |
| lock_rdata | output | 1 | Current lock bit |
| ctrl_rdata | output | 8 | Control readback |
| avail_cnt | output | 4 | Number of stored words |
| word_rdata | output | 32 | Stored word selected by the index, or 0 |

## Verification
The hardest case to reach is a system reset event that lands in the same cycle as a control write, while the lock is still set and the enable is already 1. Capture, enable override and index update then all resolve on one edge. The directed part of the stimulus builds this case on purpose. After that, a long randomized run issues control writes on most cycles and reset events often, but clears the lock only rarely. A second power-on reset partway through the run opens the lock again, so both the locked and the unlocked phases see many collisions.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  localparam int WORD_W    = 32;
  localparam int IDX_W     = 4;
  localparam int CTRL_W    = 8;
  localparam int MAX_WORDS = 15;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             en;
  } dsu_ctrl_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(dsu_ctrl_t c);
    return {c.idx, 3'b000, c.en};
  endfunction

  function automatic dsu_ctrl_t unpack_ctrl(logic [CTRL_W-1:0] w);
    dsu_ctrl_t c;
    c.idx = w[7:4];
    c.en  = w[0];
    return c;
  endfunction

  function automatic logic idx_in_range(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] cnt);
    return idx < cnt;
  endfunction

endpackage

// File: rtl/dsu_ctrl_reg.sv
module dsu_ctrl_reg
  import dsu_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              lock_we,
  input  logic              lock_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              sys_rst_evt,
  output logic              lock_q,
  output dsu_ctrl_t         ctrl_q
);

  logic      ctrl_wr_ok;
  logic      lock_clr;
  dsu_ctrl_t wr_val;

  assign ctrl_wr_ok = ctrl_we & lock_q;
  assign lock_clr   = lock_we & ~lock_wdata;
  assign wr_val     = unpack_ctrl(ctrl_wdata);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b1;
    end else if (lock_clr) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr_ok) begin
        ctrl_q.idx <= wr_val.idx;
        ctrl_q.en  <= wr_val.en;
      end
      if (sys_rst_evt) begin
        ctrl_q.en <= 1'b0;
      end
    end
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    !lock_q |=> !lock_q);

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!lock_q && ctrl_we) |=> $stable(ctrl_q.idx));

  // R5
  en_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_evt |=> !ctrl_q.en);

  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_evt && !lock_we) |=> $stable(lock_q));

endmodule

// File: rtl/dsu_store.sv
module dsu_store
  import dsu_pkg::*;
#(
  parameter int NUM_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        capture,
  input  logic [NUM_WORDS*WORD_W-1:0] dump_in,
  output logic [NUM_WORDS*WORD_W-1:0] snap_q,
  output logic [IDX_W-1:0]            cnt_q
);

  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(NUM_WORDS);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        snap_q[k*WORD_W +: WORD_W] <= '0;
      end else if (capture) begin
        snap_q[k*WORD_W +: WORD_W] <= dump_in[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (capture) begin
      cnt_q <= FULL_CNT;
    end
  end

  // R6
  cnt_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    capture |=> (cnt_q == FULL_CNT));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !capture |=> ($stable(snap_q) && $stable(cnt_q)));

endmodule

// File: rtl/dsu_readmux.sv
module dsu_readmux
  import dsu_pkg::*;
#(
  parameter int NUM_WORDS = 6
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic [IDX_W-1:0]            cnt,
  input  logic [NUM_WORDS*WORD_W-1:0] snap,
  output logic [WORD_W-1:0]           rdata
);

  localparam int SLOTS = 1 << IDX_W;

  logic [WORD_W-1:0] slot [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < NUM_WORDS) begin : g_used
      assign slot[k] = snap[k*WORD_W +: WORD_W];
    end else begin : g_empty
      assign slot[k] = '0;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx_in_range(idx, cnt)) begin
      rdata = slot[idx];
    end
  end

endmodule

// File: rtl/diag_snapshot_unit.sv
module diag_snapshot_unit
  import dsu_pkg::*;
#(
  parameter int NUM_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        sys_rst_evt,
  input  logic                        lock_we,
  input  logic                        lock_wdata,
  input  logic                        ctrl_we,
  input  logic [7:0]                  ctrl_wdata,
  input  logic [NUM_WORDS*32-1:0]     dump_in,
  output logic                        lock_rdata,
  output logic [7:0]                  ctrl_rdata,
  output logic [3:0]                  avail_cnt,
  output logic [31:0]                 word_rdata
);

  dsu_ctrl_t                   ctrl_q;
  logic                        lock_q;
  logic                        capture_fire;
  logic [NUM_WORDS*WORD_W-1:0] snap_q;
  logic [IDX_W-1:0]            cnt_q;

  assign capture_fire = sys_rst_evt & ctrl_q.en;

  dsu_ctrl_reg u_ctrl (
    .clk         (clk),
    .por_n       (por_n),
    .lock_we     (lock_we),
    .lock_wdata  (lock_wdata),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .sys_rst_evt (sys_rst_evt),
    .lock_q      (lock_q),
    .ctrl_q      (ctrl_q)
  );

  dsu_store #(.NUM_WORDS(NUM_WORDS)) u_store (
    .clk     (clk),
    .por_n   (por_n),
    .capture (capture_fire),
    .dump_in (dump_in),
    .snap_q  (snap_q),
    .cnt_q   (cnt_q)
  );

  dsu_readmux #(.NUM_WORDS(NUM_WORDS)) u_rmux (
    .idx   (ctrl_q.idx),
    .cnt   (cnt_q),
    .snap  (snap_q),
    .rdata (word_rdata)
  );

  assign lock_rdata = lock_q;
  assign ctrl_rdata = pack_ctrl(ctrl_q);
  assign avail_cnt  = cnt_q;

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    (avail_cnt == 4'd0) |-> (word_rdata == 32'd0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    ctrl_rdata[3:1] == 3'b000);

  // R6
  cap_count_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_evt && ctrl_rdata[0]) |=> (avail_cnt == 4'(NUM_WORDS)));

endmodule

// File: tb/test_diag_snapshot_unit.sv
module test_diag_snapshot_unit;

  localparam int NW = 6;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            sys_rst_evt = 1'b0;
  logic            lock_we = 1'b0;
  logic            lock_wdata = 1'b1;
  logic            ctrl_we = 1'b0;
  logic [7:0]      ctrl_wdata = '0;
  logic [NW*32-1:0] dump_in = '0;
  logic            lock_rdata;
  logic [7:0]      ctrl_rdata;
  logic [3:0]      avail_cnt;
  logic [31:0]     word_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  diag_snapshot_unit #(.NUM_WORDS(NW)) i_diag_snapshot_unit (
    .clk(clk), .por_n(por_n), .sys_rst_evt(sys_rst_evt),
    .lock_we(lock_we), .lock_wdata(lock_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .dump_in(dump_in),
    .lock_rdata(lock_rdata), .ctrl_rdata(ctrl_rdata),
    .avail_cnt(avail_cnt), .word_rdata(word_rdata)
  );

  // behavioural reference
  int          m_lock, m_en, m_idx, m_cnt;
  logic [31:0] m_snap [NW];

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_lock = 1; m_en = 0; m_idx = 0; m_cnt = 0;
      foreach (m_snap[i]) m_snap[i] = 0;
    end else begin
      int n_en, n_idx;
      n_en = m_en; n_idx = m_idx;
      if (ctrl_we && m_lock == 1) begin
        n_en  = int'(ctrl_wdata[0]);
        n_idx = int'(ctrl_wdata) / 16;
      end
      if (sys_rst_evt) begin
        if (m_en == 1) begin
          for (int i = 0; i < NW; i++) m_snap[i] = dump_in[i*32 +: 32];
          m_cnt = NW;
        end
        n_en = 0;
      end
      if (lock_we && !lock_wdata) m_lock = 0;
      m_en = n_en; m_idx = n_idx;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string phase);
    logic [31:0] exp_data;
    exp_data = (m_idx < m_cnt) ? m_snap[m_idx] : 32'd0;
    chk({phase, " R3 lock"}, 32'(lock_rdata), 32'(m_lock));
    chk({phase, " R2 ctrl"}, 32'(ctrl_rdata), 32'(m_idx * 16 + m_en));
    chk({phase, " R6 count"}, 32'(avail_cnt), 32'(m_cnt));
    chk({phase, " R8 R9 data"}, word_rdata, exp_data);
  endtask

  // one clock: inputs already set, sample at the following negedge
  task automatic tick(string phase);
    @(posedge clk);
    @(negedge clk);
    compare_all(phase);
    sys_rst_evt = 0; lock_we = 0; ctrl_we = 0;
  endtask

  function automatic logic [NW*32-1:0] make_dump(int seed);
    logic [NW*32-1:0] v;
    for (int k = 0; k < NW; k++)
      v[k*32 +: 32] = 32'(seed) * 32'h9E3779B1 ^ (32'(k) << 20) ^ 32'h5A5A0000;
    return v;
  endfunction

  task automatic wr_ctrl(logic [7:0] d);
    ctrl_we = 1; ctrl_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    por_n = 1;
    @(negedge clk);
    compare_all("R1 reset");

    // R9: nothing captured yet, every index reads 0
    wr_ctrl(8'h30); tick("R9 empty");
    chk("R9 empty data", word_rdata, 32'd0);

    // R7: reset event without enable keeps the empty snapshot
    dump_in = make_dump(1); sys_rst_evt = 1; tick("R7 idle");
    chk("R7 count kept", 32'(avail_cnt), 32'd0);

    // R2: arm with reserved bits set
    wr_ctrl(8'h2F); tick("R2 arm");
    chk("R2 readback", 32'(ctrl_rdata), 32'h21);

    // R6 and R5: capture, enable dropped, index kept (R10)
    dump_in = make_dump(2); sys_rst_evt = 1; tick("R6 capture");
    chk("R5 enable low", 32'(ctrl_rdata[0]), 32'd0);
    chk("R10 index kept", 32'(ctrl_rdata[7:4]), 32'd2);
    chk("R8 word2", word_rdata, make_dump(2)[2*32 +: 32]);

    // R7: another reset without enable keeps captured data
    dump_in = make_dump(3); sys_rst_evt = 1; tick("R7 hold");
    chk("R7 word kept", word_rdata, make_dump(2)[2*32 +: 32]);

    // R8 R9: sweep all indices
    for (int i = 0; i < 16; i++) begin
      wr_ctrl(8'(i * 16)); tick("R8 R9 sweep");
    end

    // R5: arm, then reset event collides with a write that sets enable
    wr_ctrl(8'h01); tick("R5 arm");
    dump_in = make_dump(4); sys_rst_evt = 1; wr_ctrl(8'h41); tick("R5 collide");
    chk("R5 enable forced low", 32'(ctrl_rdata), 32'h40);
    chk("R6 word4 new", word_rdata, make_dump(4)[4*32 +: 32]);

    // R3: writing 1 does nothing, writing 0 clears
    lock_we = 1; lock_wdata = 1; tick("R3 w1");
    chk("R3 lock still set", 32'(lock_rdata), 32'd1);
    wr_ctrl(8'h11); tick("R3 armed");
    lock_we = 1; lock_wdata = 0; tick("R3 w0");
    chk("R3 lock cleared", 32'(lock_rdata), 32'd0);

    // R4: locked writes ignored; R10 lock survives reset event
    wr_ctrl(8'h50); tick("R4 locked");
    chk("R4 ctrl unchanged", 32'(ctrl_rdata), 32'h11);
    dump_in = make_dump(5); sys_rst_evt = 1; tick("R10 lock");
    chk("R10 lock kept", 32'(lock_rdata), 32'd0);
    lock_we = 1; lock_wdata = 1; tick("R3 sticky");

    // random phase with a power-on reset in the middle
    for (int c = 0; c < 3000; c++) begin
      if (c == 1500) begin
        @(negedge clk); por_n = 0;
        @(negedge clk); compare_all("R1 por");
        por_n = 1;
      end
      dump_in = make_dump(100 + c);
      sys_rst_evt = ($urandom % 6) == 0;
      ctrl_we     = ($urandom % 3) != 0;
      ctrl_wdata  = 8'($urandom);
      lock_we     = ($urandom % 300) == 0;
      lock_wdata  = 1'($urandom);
      tick("rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule